// File: doc/BRIEF.md
# Cross-Coupled Parity Interconnect Self-Test Engine

This engine drives a bundle of interconnect wires with two counter-based pattern sources per wire group, passes the bundle through a one-cycle register stage, and checks the far end with two parity analyzers per group. One source counts up and the other counts down, and each appends its own parity bit. In short-line mode the up source carries odd parity and the down source carries even parity, so the two halves of a group always carry opposite parity senses. A stuck wire, or two neighbouring wires shorted together, therefore breaks the parity seen by at least one analyzer within a single run.

A single start pulse launches a run. The engine then applies every count of the selected width once, checks each received vector, and raises `done`. The fail flags are sticky and stay set until the next start or a reset. A fault-injection port sits between the driven bundle and the register stage, so a bench can force stuck-at and adjacent bridging faults without touching the engine.

Top module: `xpar_bist`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `busy`, `done`, `fail_up`, `fail_dn` and `rx_bus` are all zero.
- R2: A `start` pulse sampled at an edge sets `busy` and clears `done`, `fail_up` and `fail_dn` at that edge. This also holds during a run, and the run then restarts from its first vector.
- R3: Short-line mode (`LONG_MODE`=0) uses CW=2. In group g, wire g*6+b carries up-count bit b, wire g*6+2 carries odd parity over the up bits, wire g*6+3+b carries down-count bit b, and wire g*6+5 carries even parity over the down bits. After the start edge, `tx_bus` shows count k on the up field and ~k on the down field in the k-th cycle. Every group carries the same pattern. The first vector per group, written from wire 0 to wire 5, is 0,0,1,1,1,0.
- R4: Long-line mode (`LONG_MODE`=1) uses the same layout with CW=3, a group width of 8, and even parity on both fields. It runs through 8 vectors, and the first vector per group is 0,0,0,0,1,1,1,1.
- R5: `rx_bus` is the faulted `tx_bus`, registered one cycle later.
- R6: Fault codes on `fault_mode` are: 0 none, 1 force wire `fault_sel` to 0, 2 force it to 1, 3 wired-AND of wires `fault_sel` and `fault_sel`+1, and 4 wired-OR of the same two wires. Codes 5 to 7, a `fault_sel` at or above the bundle width, and a bridge whose `fault_sel` is the top wire all leave the bundle unchanged.
- R7: For each group, the up analyzer checks its up field plus parity against the up sense, and the down analyzer checks its down field plus parity against even parity. Analyzers compare only vectors launched during a run, so faults applied while idle set no flag.
- R8: A set fail bit stays set until the next start or reset, whatever the fault inputs do.
- R9: A run keeps `busy` high for exactly 2^CW cycles. `done` rises one cycle after `busy` falls, together with the final fail flags, and stays high until the next start.
- R10: With a single fault of codes 1 to 4 held for a whole run, at least one fail bit is set when `done` rises, for every wire and every adjacent pair in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins (or restarts) a run |
| fault_mode | input | 3 | Fault code applied to the bundle |
| fault_sel | input | SELW | Index of the faulted wire, or the lower wire of a bridged pair |
| busy | output | 1 | High while vectors are being launched |
| done | output | 1 | High from the end of a run until the next start |
| fail_up | output | GROUPS | Sticky fail flag of each group's up analyzer |
| fail_dn | output | GROUPS | Sticky fail flag of each group's down analyzer |
| tx_bus | output | NW | Driven wire bundle |
| rx_bus | output | NW | Received wire bundle after fault and register stage |

## Verification
The bound checker watches, on every cycle, the control rules: start clears the flags and sets busy; fail bits never drop without a start; no new fail bit appears unless a launched vector was in the register stage; busy lasts exactly one full count; and done follows the fall of busy. Only the bench scenarios can show the actual wire patterns of each mode, the parity senses, the fault codes and their boundary cases, and that every single stuck-at and every adjacent bridge is caught. The bench does this by comparing the flags against its own model of the bundle.

// File: rtl/xpar_bist.sv
module xpar_bist #(
  parameter int LONG_MODE = 0,
  parameter int GROUPS    = 2,
  localparam int CW   = (LONG_MODE != 0) ? 3 : 2,
  localparam int GW   = 2 * CW + 2,
  localparam int NW   = GROUPS * GW,
  localparam int SELW = $clog2(NW),
  localparam int NV   = 1 << CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        fault_mode,
  input  logic [SELW-1:0]   fault_sel,
  output logic              busy,
  output logic              done,
  output logic [GROUPS-1:0] fail_up,
  output logic [GROUPS-1:0] fail_dn,
  output logic [NW-1:0]     tx_bus,
  output logic [NW-1:0]     rx_bus
);
  localparam bit UP_ODD = (LONG_MODE == 0);

  logic [CW-1:0]     cnt;
  logic              vld_q;
  logic [NW-1:0]     rx_d;
  logic [GROUPS-1:0] up_bad, dn_bad;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign tx_bus[g*GW +: CW]        = cnt;
    assign tx_bus[g*GW + CW]         = (^cnt) ^ UP_ODD;
    assign tx_bus[g*GW + CW + 1 +: CW] = ~cnt;
    assign tx_bus[g*GW + 2*CW + 1]   = ^(~cnt);
    assign up_bad[g] = (^rx_bus[g*GW +: CW+1]) ^ UP_ODD;
    assign dn_bad[g] = ^rx_bus[g*GW + CW + 1 +: CW+1];
  end

  for (genvar i = 0; i < NW; i++) begin : g_wire
    logic own, pr_hi, pr_lo, partner, bridged;
    assign own = (fault_sel == SELW'(i));
    if (i < NW - 1) begin : g_hi
      assign pr_hi = (fault_sel == SELW'(i));
    end else begin : g_nohi
      assign pr_hi = 1'b0;
    end
    if (i > 0) begin : g_lo
      assign pr_lo = (fault_sel == SELW'(i - 1));
    end else begin : g_nolo
      assign pr_lo = 1'b0;
    end
    if (i == 0) begin : g_p0
      assign partner = tx_bus[i+1];
    end else if (i == NW - 1) begin : g_pn
      assign partner = tx_bus[i-1];
    end else begin : g_pm
      assign partner = pr_hi ? tx_bus[i+1] : tx_bus[i-1];
    end
    assign bridged = pr_hi | pr_lo;
    assign rx_d[i] = (fault_mode == 3'd1 && own)     ? 1'b0 :
                     (fault_mode == 3'd2 && own)     ? 1'b1 :
                     (fault_mode == 3'd3 && bridged) ? (tx_bus[i] & partner) :
                     (fault_mode == 3'd4 && bridged) ? (tx_bus[i] | partner) :
                                                       tx_bus[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      vld_q   <= 1'b0;
      rx_bus  <= '0;
      fail_up <= '0;
      fail_dn <= '0;
    end else begin
      rx_bus <= rx_d;
      vld_q  <= busy & ~start;
      if (start) begin
        cnt     <= '0;
        busy    <= 1'b1;
        done    <= 1'b0;
        fail_up <= '0;
        fail_dn <= '0;
      end else begin
        if (busy) begin
          cnt <= cnt + 1'b1;
          if (&cnt) busy <= 1'b0;
        end
        if (vld_q) begin
          fail_up <= fail_up | up_bad;
          fail_dn <= fail_dn | dn_bad;
          if (!busy) done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xpar_bist_chk.sv
module xpar_bist_chk #(
  parameter int GROUPS = 2,
  parameter int NV     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              vld,
  input logic [GROUPS-1:0] fail_up,
  input logic [GROUPS-1:0] fail_dn
);
  logic [15:0] blen;

  always_ff @(posedge clk) begin
    if (rst) blen <= '0;
    else if (start) blen <= '0;
    else if (busy) blen <= blen + 16'd1;
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !done && fail_up == '0 && fail_dn == '0)); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R9
  AST_UP_STICKY: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((fail_up & $past(fail_up)) == $past(fail_up))); // R8
  AST_DN_STICKY: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((fail_dn & $past(fail_dn)) == $past(fail_dn))); // R8
  AST_FAIL_GATED: assert property (@(posedge clk) disable iff (rst)
    !vld |=> (((fail_up & ~$past(fail_up)) == '0) && ((fail_dn & ~$past(fail_dn)) == '0))); // R7
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (blen == 16'(NV))); // R9
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !start) |=> done); // R9
endmodule

bind xpar_bist xpar_bist_chk #(.GROUPS(GROUPS), .NV(NV)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .vld(vld_q), .fail_up(fail_up), .fail_dn(fail_dn)
);

// File: tb/xpar_bist_tb_top.sv
`timescale 1ns/1ps
module xpar_bist_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_s = 1'b0, start_l = 1'b0;
  logic [2:0] fm_s = '0, fm_l = '0;
  logic [3:0] fs_s = '0, fs_l = '0;
  logic busy_s, done_s, busy_l, done_l;
  logic [1:0] fu_s, fd_s, fu_l, fd_l;
  logic [11:0] tx_s, rx_s;
  logic [15:0] tx_l, rx_l;
  logic use_l = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xpar_bist #(.LONG_MODE(0), .GROUPS(2)) dut_i (
    .clk(clk), .rst(rst), .start(start_s), .fault_mode(fm_s), .fault_sel(fs_s),
    .busy(busy_s), .done(done_s), .fail_up(fu_s), .fail_dn(fd_s),
    .tx_bus(tx_s), .rx_bus(rx_s));

  xpar_bist #(.LONG_MODE(1), .GROUPS(2)) dut_l (
    .clk(clk), .rst(rst), .start(start_l), .fault_mode(fm_l), .fault_sel(fs_l),
    .busy(busy_l), .done(done_l), .fail_up(fu_l), .fail_dn(fd_l),
    .tx_bus(tx_l), .rx_bus(rx_l));

  wire        o_busy = use_l ? busy_l : busy_s;
  wire        o_done = use_l ? done_l : done_s;
  wire [1:0]  o_fu   = use_l ? fu_l : fu_s;
  wire [1:0]  o_fd   = use_l ? fd_l : fd_s;
  wire [15:0] o_tx   = use_l ? tx_l : {4'b0, tx_s};
  wire [15:0] o_rx   = use_l ? rx_l : {4'b0, rx_s};

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] gen(input bit lng, input int k);
    int cw = lng ? 3 : 2;
    int gw = 2 * cw + 2;
    logic [15:0] v = '0;
    logic pu, pd;
    for (int g = 0; g < 2; g++) begin
      pu = 1'b0; pd = 1'b0;
      for (int b = 0; b < cw; b++) begin
        v[g*gw+b]      = k[b];
        v[g*gw+cw+1+b] = ~k[b];
        pu ^= k[b];
        pd ^= ~k[b];
      end
      v[g*gw+cw]     = lng ? pu : ~pu;
      v[g*gw+2*cw+1] = pd;
    end
    return v;
  endfunction

  function automatic logic [15:0] apply(input logic [15:0] v, input int mode, input int sel, input int nw);
    logic [15:0] r = v;
    logic x;
    if (sel < nw) begin
      if (mode == 1) r[sel] = 1'b0;
      else if (mode == 2) r[sel] = 1'b1;
      else if ((mode == 3 || mode == 4) && sel < nw - 1) begin
        x = (mode == 3) ? (v[sel] & v[sel+1]) : (v[sel] | v[sel+1]);
        r[sel] = x; r[sel+1] = x;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_fail(input bit lng, input int mode, input int sel);
    int cw = lng ? 3 : 2;
    int gw = 2 * cw + 2;
    int nw = 2 * gw;
    logic [3:0] f = '0;
    logic [15:0] r;
    logic pu, pd;
    for (int k = 0; k < (1 << cw); k++) begin
      r = apply(gen(lng, k), mode, sel, nw);
      for (int g = 0; g < 2; g++) begin
        pu = 1'b0; pd = 1'b0;
        for (int b = 0; b <= cw; b++) begin
          pu ^= r[g*gw+b];
          pd ^= r[g*gw+cw+1+b];
        end
        if (pu != (lng ? 1'b0 : 1'b1)) f[g] = 1'b1;
        if (pd) f[2+g] = 1'b1;
      end
    end
    return f;
  endfunction

  task automatic set_fault(input bit lng, input int mode, input int sel);
    if (lng) begin fm_l = 3'(mode); fs_l = 4'(sel); end
    else begin fm_s = 3'(mode); fs_s = 4'(sel); end
  endtask

  task automatic pulse_start(input bit lng);
    use_l = lng;
    @(negedge clk);
    start_s = !lng; start_l = lng;
    @(negedge clk);
    start_s = 1'b0; start_l = 1'b0;
  endtask

  // full run with per-cycle checks of pattern, bundle, timing and flags
  task automatic run(input bit lng, input int mode, input int sel, input bit want_detect);
    int nv = lng ? 8 : 4;
    int nw = lng ? 16 : 12;
    logic [15:0] mask = lng ? 16'hFFFF : 16'h0FFF;
    logic [3:0] ef = exp_fail(lng, mode, sel);
    set_fault(lng, mode, sel);
    pulse_start(lng);
    chk(o_fu == 2'b0 && o_fd == 2'b0 && !o_done, "R2 start clears", {12'b0, o_fu, o_fd}, 16'h0);
    for (int k = 0; k < nv; k++) begin
      if (k > 0) @(negedge clk);
      chk(o_busy, "R9 busy during run", {15'b0, o_busy}, 16'h1);
      chk((o_tx & mask) == (gen(lng, k) & mask), lng ? "R4 long pattern" : "R3 short pattern", o_tx, gen(lng, k) & mask);
      if (k > 0)
        chk((o_rx & mask) == (apply(gen(lng, k-1), mode, sel, nw) & mask), "R5 R6 received bundle",
            o_rx, apply(gen(lng, k-1), mode, sel, nw) & mask);
    end
    @(negedge clk);
    chk(!o_busy && !o_done, "R9 busy falls, done not yet", {14'b0, o_busy, o_done}, 16'h0);
    chk((o_rx & mask) == (apply(gen(lng, nv-1), mode, sel, nw) & mask), "R5 last vector",
        o_rx, apply(gen(lng, nv-1), mode, sel, nw) & mask);
    @(negedge clk);
    chk(o_done, "R9 done", {15'b0, o_done}, 16'h1);
    chk({o_fd, o_fu} == ef, "R7 analyzer flags", {12'b0, o_fd, o_fu}, {12'b0, ef});
    if (want_detect)
      chk((o_fu | o_fd) != 2'b0, "R10 fault detected", {12'b0, o_fd, o_fu}, 16'hF);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      use_l = (m == 1);
      #0.1;
      chk(!o_busy && !o_done && o_fu == 0 && o_fd == 0 && o_rx == 0, "R1 reset state",
          {o_rx[13:0], o_busy, o_done}, 16'h0);
    end
  endtask

  task automatic t_clean();
    run(1'b0, 0, 0, 1'b0);   // R3 first vector 001110 per group
    chk(gen(1'b0, 0)[5:0] == 6'b011100, "R3 first vector bits", {10'b0, gen(1'b0, 0)[5:0]}, 16'h1C);
    run(1'b1, 0, 0, 1'b0);   // R4
  endtask

  task automatic t_ignored();
    // R6: codes with no effect
    run(1'b0, 5, 3, 1'b0);
    run(1'b0, 3, 11, 1'b0);
    run(1'b0, 1, 13, 1'b0);
    run(1'b1, 4, 15, 1'b0);
    // R7: faults while idle set nothing
    set_fault(1'b0, 2, 0);
    repeat (6) @(negedge clk);
    use_l = 1'b0;
    chk(fu_s == 0 && fd_s == 0 && done_s, "R7 idle fault ignored", {12'b0, fd_s, fu_s}, 16'h0);
    set_fault(1'b0, 0, 0);
  endtask

  task automatic t_sticky();
    run(1'b0, 1, 2, 1'b1);   // up parity wire of group 0 stuck low
    set_fault(1'b0, 0, 0);
    repeat (5) @(negedge clk);
    chk(fu_s == 2'b01 && fd_s == 2'b00, "R8 flag held", {12'b0, fd_s, fu_s}, 16'h1);
    run(1'b0, 0, 0, 1'b0);   // R8 cleared by new start
  endtask

  task automatic t_restart();
    pulse_start(1'b0);
    repeat (2) @(negedge clk);
    run(1'b0, 0, 0, 1'b0);   // R2 restart mid-run, full length afterwards
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++) begin
      int nw = m ? 16 : 12;
      for (int mode = 1; mode <= 4; mode++)
        for (int s = 0; s < ((mode >= 3) ? nw - 1 : nw); s++)
          run(m[0], mode, s, 1'b1);   // R10
      set_fault(m[0], 0, 0);
    end
  endtask

  initial begin
    t_reset();
    t_clean();
    t_ignored();
    t_sticky();
    t_restart();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500us;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule